// File: doc/BRIEF.md
# GPIO Edge-Cause Interrupt Aggregator

This block watches a port of general-purpose input pins and turns chosen signal transitions into interrupt causes. Each pin is brought into the clock domain by a two-flop synchronizer. A transition is found by comparing the synchronized value with the sample from the cycle before. Per pin, software picks whether a low-to-high transition, a high-to-low transition, or either one latches a sticky cause bit.

Latched causes are gated by a per-pin event-enable mask and reduced to a single level-sensitive interrupt. That line can be shared with other sources. A handler reads the masked pending view, services the pins it finds, and writes the same pattern back to the clear register; each one in the write clears the matching cause. Masking a pin only hides it. Its cause stays latched and shows up again when the pin is unmasked.

Every register is reached over one simple 32-bit register bus. A write takes effect on the clock edge at which it is presented. Read data is registered and valid one cycle after the read strobe.

Top module: `gpio_edge_irq_agg`

## Requirements
- R1: After reset, the rise-enable, fall-enable and event-enable registers and all cause bits are zero, `irq_o` is low, and `bus_rdata` is zero.
- R2: With bit i of the rise-enable register (offset 0x44) set, a low-to-high change on `pin_i[i]` sets cause bit i.
- R3: With bit i of the fall-enable register (offset 0x48) set, a high-to-low change on `pin_i[i]` sets cause bit i.
- R4: With both enable bits of a pin set, either kind of change sets that pin's cause bit.
- R5: A pin change whose direction is not enabled leaves the cause bit clear.
- R6: Cause bits latch whatever the event-enable register (offset 0x94) holds. Masking a pin does not discard its cause: reading offset 0x98 returns the raw causes.
- R7: Reading offset 0x80 returns the cause bits ANDed with the event-enable register.
- R8: `irq_o` is high while any cause bit is set with its event-enable bit also set, and low otherwise; it follows one cycle after the cause or mask change.
- R9: Writing to offset 0x98 clears each cause bit written as 1 and keeps each bit written as 0.
- R10: When a pin change sets a cause bit in the same cycle that a clear write targets it, the bit ends set.
- R11: The enable registers at 0x44, 0x48 and 0x94 read back the value last written.
- R12: A write to the read-only offset 0x80 changes no cause bit, and a read of any offset not listed above returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 32 | Asynchronous pin levels |
| bus_addr | input | 8 | Register byte offset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe; data valid next cycle |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level-sensitive shared interrupt |

## Verification
The assertions assume that the bus strobes are free of unknown values and that a pin input holds each new level for at least two clock cycles, so that the synchronizer never drops a change. The stimulus changes pins only at the falling clock edge and holds every pattern for several cycles. It issues one register access at a time. The only deliberate collision between a pin change and a clear write is placed on the exact cycle in which the change reaches the cause register.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 8'h80; // masked cause view, read-only
  localparam logic [ADDR_W-1:0] OFS_RISE   = 8'h44; // rise-cause enable
  localparam logic [ADDR_W-1:0] OFS_FALL   = 8'h48; // fall-cause enable
  localparam logic [ADDR_W-1:0] OFS_EVEN   = 8'h94; // event-enable mask
  localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h98; // W1C clear / raw cause read
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int N_PINS = 32,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] sync_o
);
  logic [N_PINS-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= pin_i;
  end

  genvar s;
  generate
    for (s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_cause_bank.sv
module gpio_cause_bank #(
  parameter int N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] sync_i,
  input  logic [N_PINS-1:0] rise_en_i,
  input  logic [N_PINS-1:0] fall_en_i,
  input  logic [N_PINS-1:0] clr_i,
  output logic [N_PINS-1:0] cause_o
);
  logic [N_PINS-1:0] prev_q;
  logic [N_PINS-1:0] set_vec;
  logic [N_PINS-1:0] cause_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sync_i;
  end

  genvar i;
  generate
    for (i = 0; i < N_PINS; i++) begin : g_pin
      logic rise_hit, fall_hit;
      assign rise_hit   = rise_en_i[i] &  sync_i[i] & ~prev_q[i];
      assign fall_hit   = fall_en_i[i] & ~sync_i[i] &  prev_q[i];
      assign set_vec[i] = rise_hit | fall_hit;

      // set has priority over a same-cycle clear
      always_ff @(posedge clk) begin
        if (rst)             cause_q[i] <= 1'b0;
        else if (set_vec[i]) cause_q[i] <= 1'b1;
        else if (clr_i[i])   cause_q[i] <= 1'b0;
      end
    end
  endgenerate

  assign cause_o = cause_q;

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((cause_q & $past(set_vec)) == $past(set_vec)));

  // R9
  clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (|clr_i) |=> ((cause_q & $past(clr_i & ~set_vec)) == '0));

  // R5
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [N_PINS-1:0] bus_wdata,
  input  logic              bus_rd_en,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_PINS-1:0] cause_i,
  output logic [N_PINS-1:0] rise_en_o,
  output logic [N_PINS-1:0] fall_en_o,
  output logic [N_PINS-1:0] clr_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] rise_q, fall_q, mask_q;
  logic [N_PINS-1:0] rd_mux;
  logic [N_PINS-1:0] pending;
  logic              irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= '0;
      fall_q <= '0;
      mask_q <= '0;
    end else if (bus_wr_en) begin
      case (bus_addr)
        OFS_RISE: rise_q <= bus_wdata;
        OFS_FALL: fall_q <= bus_wdata;
        OFS_EVEN: mask_q <= bus_wdata;
        default:  ;
      endcase
    end
  end

  assign clr_o   = (bus_wr_en && bus_addr == OFS_CLR) ? bus_wdata : '0;
  assign pending = cause_i & mask_q;

  always_comb begin
    case (bus_addr)
      OFS_MASKED: rd_mux = pending;
      OFS_RISE:   rd_mux = rise_q;
      OFS_FALL:   rd_mux = fall_q;
      OFS_EVEN:   rd_mux = mask_q;
      OFS_CLR:    rd_mux = cause_i;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_q     <= 1'b0;
    end else begin
      bus_rdata <= bus_rd_en ? rd_mux : '0;
      irq_q     <= |pending;
    end
  end

  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
  assign irq_o     = irq_q;

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((cause_i & mask_q) == '0) |=> !irq_o);

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($past(cause_i) != '0));

  // R7
  rd_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && bus_addr == OFS_MASKED) |=> ((bus_rdata & ~$past(mask_q)) == '0));
endmodule

// File: rtl/gpio_edge_irq_agg.sv
module gpio_edge_irq_agg
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [N_PINS-1:0] bus_wdata,
  input  logic              bus_rd_en,
  output logic [N_PINS-1:0] bus_rdata,
  output logic              irq_o
);
  logic [N_PINS-1:0] sync_w, rise_w, fall_w, clr_w, cause_w;

  gpio_pin_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .pin_i(pin_i), .sync_o(sync_w)
  );

  gpio_cause_bank #(.N_PINS(N_PINS)) cause_i (
    .clk(clk), .rst(rst), .sync_i(sync_w), .rise_en_i(rise_w),
    .fall_en_i(fall_w), .clr_i(clr_w), .cause_o(cause_w)
  );

  gpio_irq_regs #(.N_PINS(N_PINS)) regs_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
    .cause_i(cause_w), .rise_en_o(rise_w), .fall_en_o(fall_w),
    .clr_o(clr_w), .irq_o(irq_o)
  );
endmodule

// File: tb/gpio_edge_irq_agg_tb.sv
`timescale 1ns/1ps
module gpio_edge_irq_agg_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_i = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd_en = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  gpio_edge_irq_agg dut_i (
    .clk(clk), .rst(rst), .pin_i(pin_i), .bus_addr(bus_addr),
    .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [31:0] rise, fall, mask, p0, p1, raw, masked;
    logic        irq;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VT [NV] = '{
    '{32'h0000_00FF, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0000_0F0F, 32'h0000_000F, 32'h0000_000F, 1'b1}, // R2
    '{32'h0, 32'hFFFF_0000, 32'h00FF_0000, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_0000, 32'h00FF_0000, 1'b1}, // R3
    '{32'h0000_000F, 32'h0000_000F, 32'h0000_000F, 32'h5, 32'hA, 32'hF, 32'hF, 1'b1}, // R4
    '{32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h8000_0001, 32'h8000_0001, 32'h0, 1'b0}, // R6
    '{32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0}, // R5
    '{32'h0000_00F0, 32'h0000_0F00, 32'h0000_0FF0, 32'h0000_0F00, 32'h0000_00F0, 32'h0000_0FF0, 32'h0000_0FF0, 1'b1} // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rd(8'h44, d); check("R1 rise", d, 32'h0);
    rd(8'h94, d); check("R1 mask", d, 32'h0);
    rd(8'h98, d); check("R1 cause", d, 32'h0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      pin_i = VT[v].p0; settle();
      wr(8'h44, VT[v].rise);
      wr(8'h48, VT[v].fall);
      wr(8'h94, VT[v].mask);
      pin_i = VT[v].p1; settle();
      rd(8'h98, d);  check($sformatf("R2/R3/R4/R5 raw v%0d", v), d, VT[v].raw);
      rd(8'h80, d);  check($sformatf("R7 masked v%0d", v), d, VT[v].masked);
      check($sformatf("R8 irq v%0d", v), {31'b0, irq_o}, {31'b0, VT[v].irq});
      wr(8'h44, 32'h0); wr(8'h48, 32'h0);
      wr(8'h98, 32'hFFFF_FFFF); settle();
    end

    // R11: enable readback
    wr(8'h44, 32'hA5A5_0F0F); wr(8'h48, 32'h1234_5678); wr(8'h94, 32'hDEAD_BEEF);
    rd(8'h44, d); check("R11 rise", d, 32'hA5A5_0F0F);
    rd(8'h48, d); check("R11 fall", d, 32'h1234_5678);
    rd(8'h94, d); check("R11 mask", d, 32'hDEAD_BEEF);

    // R9: partial clear
    wr(8'h44, 32'hFFFF_FFFF); wr(8'h48, 32'h0); wr(8'h94, 32'hFFFF_FFFF);
    pin_i = '0; settle();
    wr(8'h98, 32'hFFFF_FFFF);
    pin_i = 32'h0000_00FF; settle();
    wr(8'h98, 32'h0000_000F);
    rd(8'h98, d); check("R9 partial", d, 32'h0000_00F0);

    // R12: write to read-only view, unknown offset
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h98, d); check("R12 ro write", d, 32'h0000_00F0);
    rd(8'h10, d); check("R12 unknown", d, 32'h0);

    // R6 / R8: mask hides but keeps cause
    wr(8'h94, 32'h0); @(negedge clk);
    check("R8 masked low", {31'b0, irq_o}, 32'h0);
    rd(8'h98, d); check("R6 kept", d, 32'h0000_00F0);
    wr(8'h94, 32'h0000_0010); @(negedge clk);
    check("R8 unmask high", {31'b0, irq_o}, 32'h1);
    wr(8'h98, 32'h0000_00F0); @(negedge clk);
    check("R8 cleared low", {31'b0, irq_o}, 32'h0);

    // R10: set beats same-cycle clear (cause set on 3rd edge after change)
    wr(8'h98, 32'hFFFF_FFFF);
    pin_i = 32'h0000_01FF;          // bit 8 rises
    @(negedge clk); @(negedge clk); // past edges 0 and 1
    wr(8'h98, 32'h0000_0100);       // commits at edge 2 with the set
    rd(8'h98, d); check("R10 set wins", d, 32'h0000_0100);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule